// File: doc/BRIEF.md
# Bundle and Tile Corner Address Sequencer

This block turns one broadcast bundle descriptor into a stream of sub-tile address groups for a volume rendering pipeline. A descriptor carries a start point in 3D space and three step vectors: one along the rays of the bundle (depth), one across a tile column and one down a tile row. For every depth plane the block forms a single reference point. It lays a grid of tile corners over that plane with nothing but additions and queues the corners in a small FIFO. A selector then hands out one group of four corners per tile.

Coordinates are unsigned 16-bit fixed point with 8 fractional bits, held per axis and packed as {z, y, x}, with x in the low bits. All arithmetic wraps modulo 2^16. The number of planes and the tile grid size are parameters. The descriptor side and the sub-tile side each use a valid/ready handshake. A one-cycle done pulse marks the end of a bundle.

Top module: `tile_addr_seq`

## Requirements
- R1: After reset `desc_ready_o` is 1. A descriptor is taken on a clock edge where `desc_valid_i` and `desc_ready_o` are both 1. `desc_ready_o` is then 0 until the done pulse, and any descriptor offered while it is 0 has no effect on the output stream.
- R2: The corner at index 0 of the first sub-tile of a bundle equals the descriptor origin.
- R3: The reference point of plane p (p from 0) is origin + p*ray_inc, per axis, modulo 2^16.
- R4: The corner at row r, column c of plane p is origin + p*ray_inc + c*col_inc + r*row_inc, per axis, modulo 2^16, where r runs 0..TILES_Y and c runs 0..TILES_X.
- R5: Sub-tile (r,c), with r in 1..TILES_Y and c in 1..TILES_X, packs four 48-bit corners in `tile_o`. Bits [47:0] hold corner (r-1,c-1), bits [95:48] hold (r-1,c), bits [143:96] hold (r,c-1) and bits [191:144] hold (r,c).
- R6: Sub-tiles leave plane by plane and, within a plane, row by row and then column by column. Exactly TILES_X*TILES_Y*NUM_PLANES sub-tiles are produced per descriptor.
- R7: While `tile_valid_o` is 1 and `tile_ready_i` is 0, `tile_valid_o` stays 1 and `tile_o` stays unchanged on the next cycle.
- R8: Under any pattern of back-pressure, the corner FIFO (FIFO_DEPTH entries) is never written when full or read when empty, and no corner is lost or repeated.
- R9: `done_o` pulses high for exactly one cycle, in the cycle after the last sub-tile is handed off. In that cycle `tile_valid_o` is 0 and `desc_ready_o` is 1.
- R10: During and right after reset, `tile_valid_o` and `done_o` are 0 and `desc_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Block idle, descriptor can be taken |
| origin_i | input | 48 | Bundle start point {z,y,x} |
| ray_inc_i | input | 48 | Step between depth planes {z,y,x} |
| col_inc_i | input | 48 | Step between tile columns {z,y,x} |
| row_inc_i | input | 48 | Step between tile rows {z,y,x} |
| tile_valid_o | output | 1 | Sub-tile corner group valid |
| tile_ready_i | input | 1 | Downstream takes the sub-tile |
| tile_o | output | 192 | Four corners of the sub-tile |
| done_o | output | 1 | One-cycle pulse after the last sub-tile of the bundle |

## Verification
`desc_ready_o` falls in the cycle after the accepting edge. `done_o` and the return of `desc_ready_o` are due one cycle after the handoff edge of the last sub-tile. The bench samples every output on the falling clock edge and checks these two results in exactly those cycles. Sub-tile timing depends on the FIFO and on back-pressure, so the bench does not check a fixed latency for it. Instead it counts the handoffs, matches each one against the corner formula by its position in the stream, and checks that any sub-tile held under back-pressure is still present and unchanged one sample later.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam int CW   = 16;
  localparam int FRAC = 8;

  typedef struct packed {
    logic [CW-1:0] z;
    logic [CW-1:0] y;
    logic [CW-1:0] x;
  } coord_t;

  typedef struct packed {
    logic   last;
    coord_t pt;
  } corner_t;

  function automatic coord_t add3(coord_t a, coord_t b);
    coord_t s;
    s.x = a.x + b.x;
    s.y = a.y + b.y;
    s.z = a.z + b.z;
    return s;
  endfunction
endpackage

// File: rtl/tas_plane_step.sv
module tas_plane_step
  import tas_pkg::*;
#(
  parameter int NUM_PLANES = 512
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  coord_t origin_i,
  input  coord_t ray_i,
  input  logic   ref_ready_i,
  output logic   ref_valid_o,
  output coord_t ref_o,
  output logic   ref_last_o
);
  localparam int PW = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1;
  localparam logic [PW-1:0] PLAST = PW'(NUM_PLANES - 1);

  logic [PW-1:0] cnt_q;
  logic          valid_q;
  coord_t        ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
      ref_q   <= '0;
    end else if (start_i) begin
      cnt_q   <= '0;
      valid_q <= 1'b1;
      ref_q   <= origin_i;
    end else if (valid_q && ref_ready_i) begin
      if (cnt_q == PLAST) begin
        valid_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        ref_q <= add3(ref_q, ray_i);
      end
    end
  end

  assign ref_valid_o = valid_q;
  assign ref_o       = ref_q;
  assign ref_last_o  = (cnt_q == PLAST);

  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ref_ready_i && !start_i |=> valid_q && $stable(ref_q)); // R3
endmodule

// File: rtl/tas_corner_gen.sv
module tas_corner_gen
  import tas_pkg::*;
#(
  parameter int TILES_X = 4,
  parameter int TILES_Y = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ref_valid_i,
  input  coord_t  ref_i,
  input  logic    ref_last_i,
  output logic    ref_ready_o,
  input  coord_t  col_i,
  input  coord_t  row_i,
  input  logic    full_i,
  output logic    push_o,
  output corner_t corner_o
);
  localparam int CXW = $clog2(TILES_X + 1);
  localparam int CYW = $clog2(TILES_Y + 1);
  localparam logic [CXW-1:0] CMAX = CXW'(TILES_X);
  localparam logic [CYW-1:0] RMAX = CYW'(TILES_Y);

  logic           busy_q, lastp_q;
  coord_t         cur_q, rowb_q;
  logic [CXW-1:0] c_q;
  logic [CYW-1:0] r_q;
  logic           end_col, end_row;

  assign end_col     = (c_q == CMAX);
  assign end_row     = (r_q == RMAX);
  assign ref_ready_o = !busy_q;
  assign push_o      = busy_q && !full_i;
  assign corner_o.pt   = cur_q;
  assign corner_o.last = lastp_q && end_col && end_row;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      lastp_q <= 1'b0;
      cur_q   <= '0;
      rowb_q  <= '0;
      c_q     <= '0;
      r_q     <= '0;
    end else if (!busy_q) begin
      if (ref_valid_i) begin
        busy_q  <= 1'b1;
        lastp_q <= ref_last_i;
        cur_q   <= ref_i;
        rowb_q  <= ref_i;
        c_q     <= '0;
        r_q     <= '0;
      end
    end else if (push_o) begin
      if (end_col) begin
        c_q    <= '0;
        rowb_q <= add3(rowb_q, row_i);
        cur_q  <= add3(rowb_q, row_i);
        if (end_row) busy_q <= 1'b0;
        else         r_q    <= r_q + 1'b1;
      end else begin
        c_q   <= c_q + 1'b1;
        cur_q <= add3(cur_q, col_i);
      end
    end
  end

  AST_GEN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && full_i |=> busy_q && $stable(cur_q)); // R8
endmodule

// File: rtl/tas_fifo.sv
module tas_fifo #(
  parameter int WIDTH = 49,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);
  localparam logic [AW:0]   CFULL = (AW + 1)'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [AW:0]      cnt_q;

  assign full_o    = (cnt_q == CFULL);
  assign empty_o   = (cnt_q == '0);
  assign rd_data_o = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (wr_i && !full_o) mem_q[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i && !full_o) wp_q <= (wp_q == PMAX) ? '0 : wp_q + 1'b1;
      if (rd_i && !empty_o) rp_q <= (rp_q == PMAX) ? '0 : rp_q + 1'b1;
      case ({wr_i && !full_o, rd_i && !empty_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o); // R8
endmodule

// File: rtl/tas_subtile_sel.sv
module tas_subtile_sel
  import tas_pkg::*;
#(
  parameter int TILES_X = 4,
  parameter int TILES_Y = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         empty_i,
  input  corner_t      head_i,
  output logic         pop_o,
  input  logic         out_ready_i,
  output logic         out_valid_o,
  output coord_t [3:0] out_tile_o,
  output logic         out_last_o
);
  localparam int CXW = $clog2(TILES_X + 1);
  localparam int CYW = $clog2(TILES_Y + 1);
  localparam logic [CXW-1:0] CMAX = CXW'(TILES_X);
  localparam logic [CYW-1:0] RMAX = CYW'(TILES_Y);

  coord_t         row_q [TILES_X+1];
  coord_t         diag_q, prev_q;
  coord_t [3:0]   tile_q;
  logic           valid_q, last_q;
  logic [CXW-1:0] c_q;
  logic [CYW-1:0] r_q;
  logic           emit;

  assign pop_o = !empty_i && (!valid_q || out_ready_i);
  assign emit  = pop_o && (r_q != '0) && (c_q != '0);

  // Line of the previous row; diag_q keeps corner (r-1,c-1) before overwrite
  always_ff @(posedge clk_i) begin
    if (pop_o) row_q[c_q] <= head_i.pt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diag_q  <= '0;
      prev_q  <= '0;
      tile_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      c_q     <= '0;
      r_q     <= '0;
    end else begin
      if (valid_q && out_ready_i) valid_q <= 1'b0;
      if (pop_o) begin
        diag_q <= row_q[c_q];
        prev_q <= head_i.pt;
        if (c_q == CMAX) begin
          c_q <= '0;
          r_q <= (r_q == RMAX) ? '0 : r_q + 1'b1;
        end else begin
          c_q <= c_q + 1'b1;
        end
        if (emit) begin
          tile_q  <= {head_i.pt, prev_q, row_q[c_q], diag_q};
          valid_q <= 1'b1;
          last_q  <= head_i.last;
        end
      end
    end
  end

  assign out_valid_o = valid_q;
  assign out_tile_o  = tile_q;
  assign out_last_o  = last_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !out_ready_i |=> valid_q && $stable(tile_q)); // R7
endmodule

// File: rtl/tile_addr_seq.sv
module tile_addr_seq
  import tas_pkg::*;
#(
  parameter int NUM_PLANES = 512,
  parameter int TILES_X    = 4,
  parameter int TILES_Y    = 4,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic [3*CW-1:0]   origin_i,
  input  logic [3*CW-1:0]   ray_inc_i,
  input  logic [3*CW-1:0]   col_inc_i,
  input  logic [3*CW-1:0]   row_inc_i,
  output logic              tile_valid_o,
  input  logic              tile_ready_i,
  output logic [12*CW-1:0]  tile_o,
  output logic              done_o
);
  localparam int EW = $bits(corner_t);

  logic    busy_q, done_q, accept;
  coord_t  ray_q, col_q, row_q;
  logic    ref_valid, ref_ready, ref_last;
  coord_t  ref_pt;
  logic    push, pop, full, empty;
  corner_t gen_corner, head;
  logic [EW-1:0] head_raw;
  coord_t [3:0]  tile;
  logic    tile_valid, tile_last, handoff_last;

  assign accept       = desc_valid_i && !busy_q;
  assign handoff_last = tile_valid && tile_ready_i && tile_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ray_q  <= '0;
      col_q  <= '0;
      row_q  <= '0;
    end else begin
      done_q <= handoff_last;
      if (accept) begin
        busy_q <= 1'b1;
        ray_q  <= coord_t'(ray_inc_i);
        col_q  <= coord_t'(col_inc_i);
        row_q  <= coord_t'(row_inc_i);
      end else if (handoff_last) begin
        busy_q <= 1'b0;
      end
    end
  end

  tas_plane_step #(.NUM_PLANES(NUM_PLANES)) u_plane (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .origin_i    (coord_t'(origin_i)),
    .ray_i       (ray_q),
    .ref_ready_i (ref_ready),
    .ref_valid_o (ref_valid),
    .ref_o       (ref_pt),
    .ref_last_o  (ref_last)
  );

  tas_corner_gen #(.TILES_X(TILES_X), .TILES_Y(TILES_Y)) u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_valid_i (ref_valid),
    .ref_i       (ref_pt),
    .ref_last_i  (ref_last),
    .ref_ready_o (ref_ready),
    .col_i       (col_q),
    .row_i       (row_q),
    .full_i      (full),
    .push_o      (push),
    .corner_o    (gen_corner)
  );

  tas_fifo #(.WIDTH(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (push),
    .wr_data_i (gen_corner),
    .rd_i      (pop),
    .rd_data_o (head_raw),
    .full_o    (full),
    .empty_o   (empty)
  );

  assign head = corner_t'(head_raw);

  tas_subtile_sel #(.TILES_X(TILES_X), .TILES_Y(TILES_Y)) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .empty_i     (empty),
    .head_i      (head),
    .pop_o       (pop),
    .out_ready_i (tile_ready_i),
    .out_valid_o (tile_valid),
    .out_tile_o  (tile),
    .out_last_o  (tile_last)
  );

  assign desc_ready_o = !busy_q;
  assign tile_valid_o = tile_valid;
  assign tile_o       = tile;
  assign done_o       = done_q;

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tile_valid_o && desc_ready_o); // R9
  AST_BUSY_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tile_valid_o |-> !desc_ready_o); // R1
endmodule

// File: tb/sim_tile_addr_seq.sv
module sim_tile_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int TX = 3;
  localparam int TY = 2;
  localparam int PER_PLANE = TX * TY;
  localparam int TOTAL = PER_PLANE * NP;

  typedef struct packed {
    logic [47:0] org;
    logic [47:0] ray;
    logic [47:0] col;
    logic [47:0] row;
    logic [3:0]  rdy;
    logic        junk;
  } vec_t;

  // {z,y,x} per 48-bit field
  localparam vec_t VECS [4] = '{
    '{48'h0100_0200_0300, 48'h0100_0000_0000, 48'h0000_0000_0080, 48'h0000_0080_0000, 4'b1111, 1'b0},
    '{48'h1234_0567_0ABC, 48'h0040_0010_0020, 48'h0003_0100_0011, 48'h0100_0002_0007, 4'b0101, 1'b0},
    '{48'hFF00_FE80_FFC0, 48'h0180_0180_0180, 48'h0180_0000_0180, 48'h0000_0180_0180, 4'b1011, 1'b1},
    '{48'h0800_0800_0800, 48'hFF80_0000_0010, 48'h0000_FF80_0040, 48'hFFC0_0040_0000, 4'b0001, 1'b0}
  };

  logic clk, rst_n;
  logic desc_valid, desc_ready, tile_valid, tile_ready, done;
  logic [47:0] origin, ray_inc, col_inc, row_inc;
  logic [191:0] tile;
  int n_chk, n_fail;

  tile_addr_seq #(.NUM_PLANES(NP), .TILES_X(TX), .TILES_Y(TY), .FIFO_DEPTH(16)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .desc_valid_i (desc_valid),
    .desc_ready_o (desc_ready),
    .origin_i     (origin),
    .ray_inc_i    (ray_inc),
    .col_inc_i    (col_inc),
    .row_inc_i    (row_inc),
    .tile_valid_o (tile_valid),
    .tile_ready_i (tile_ready),
    .tile_o       (tile),
    .done_o       (done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_pt(vec_t v, int p, int r, int c);
    logic [47:0] res;
    for (int i = 0; i < 3; i++) begin
      logic [15:0] a;
      a = v.org[16*i +: 16] + v.ray[16*i +: 16] * 16'(p)
        + v.col[16*i +: 16] * 16'(c) + v.row[16*i +: 16] * 16'(r);
      res[16*i +: 16] = a;
    end
    return res;
  endfunction

  function automatic logic [191:0] exp_tile(vec_t v, int k);
    int p, rem, r, c;
    p   = k / PER_PLANE;
    rem = k % PER_PLANE;
    r   = rem / TX + 1;
    c   = rem % TX + 1;
    return {exp_pt(v, p, r, c), exp_pt(v, p, r, c - 1),
            exp_pt(v, p, r - 1, c), exp_pt(v, p, r - 1, c - 1)};
  endfunction

  task automatic run_vec(input int idx);
    vec_t v;
    int k, cyc;
    bit held, fin, done_seen_early;
    logic [191:0] held_tile;
    v = VECS[idx];
    @(negedge clk);
    chk(desc_ready == 1'b1, "R1 idle before descriptor", {191'b0, desc_ready}, 192'd1);
    origin = v.org; ray_inc = v.ray; col_inc = v.col; row_inc = v.row;
    desc_valid = 1'b1;
    @(negedge clk);
    chk(desc_ready == 1'b0, "R1 ready low after accept", {191'b0, desc_ready}, 192'd0);
    if (v.junk) begin
      origin = 48'h5555_5555_5555; ray_inc = 48'h1111_1111_1111;
      col_inc = 48'h2222_2222_2222; row_inc = 48'h3333_3333_3333;
    end else begin
      desc_valid = 1'b0;
    end
    k = 0; held = 0; fin = 0; done_seen_early = 0;
    for (cyc = 0; cyc < 3000 && !fin; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (v.junk && cyc == 20) desc_valid = 1'b0;
      if (k == TOTAL) begin
        chk(done == 1'b1 && desc_ready == 1'b1 && tile_valid == 1'b0,
            "R9 done pulse after last handoff", {189'b0, done, desc_ready, tile_valid}, 192'b110);
        fin = 1;
      end else begin
        if (done) done_seen_early = 1;
        if (held) begin
          chk(tile_valid == 1'b1 && tile == held_tile, "R7 held sub-tile stable", tile, held_tile);
          held = 0;
        end
        tile_ready = v.rdy[cyc % 4];
        if (tile_valid) begin
          if (tile_ready) begin
            if (k == 0)
              chk(tile[47:0] == v.org, "R2 first corner is origin", {144'b0, tile[47:0]}, {144'b0, v.org});
            chk(tile == exp_tile(v, k), (k % PER_PLANE == 0) ? "R3 R5 plane start sub-tile" : "R4 R5 R6 sub-tile",
                tile, exp_tile(v, k));
            k++;
          end else begin
            held = 1;
            held_tile = tile;
          end
        end
      end
    end
    chk(fin, "R8 R6 all sub-tiles delivered", 192'(k), 192'(TOTAL));
    chk(!done_seen_early, "R9 no early done", {191'b0, done_seen_early}, 192'd0);
    @(negedge clk);
    chk(done == 1'b0 && tile_valid == 1'b0, "R6 R9 single pulse, no extra sub-tile",
        {190'b0, done, tile_valid}, 192'd0);
    tile_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; desc_valid = 1'b0; tile_ready = 1'b0;
    origin = '0; ray_inc = '0; col_inc = '0; row_inc = '0;
    repeat (3) @(negedge clk);
    chk(tile_valid == 1'b0 && done == 1'b0 && desc_ready == 1'b1, "R10 reset state",
        {189'b0, tile_valid, done, desc_ready}, 192'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tile_valid == 1'b0 && done == 1'b0 && desc_ready == 1'b1, "R10 after reset release",
        {189'b0, tile_valid, done, desc_ready}, 192'b001);
    for (int i = 0; i < 4; i++) run_vec(i);
    // back-to-back bundle after a junk-offer run: first run's stream must be unaffected (R1)
    run_vec(0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule